// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block is the target side of a narrow asynchronous SCSI bus. It watches for an initiator selecting its own ID, claims the bus by raising BSY, and then drives the three phase lines (MSG, C/D, I/O) through the information transfer phases. Every byte in those phases moves with a four-step REQ/ACK handshake. The target always takes a six-byte command block first. It then moves data in either direction, returns one status byte, and finishes with a one-byte completion message before it releases the bus.

A local strobe interface links the block to the command executor. A captured command block is presented with `cmd_valid`. The executor answers with `loc_go`, which carries the data direction, the byte count and the status byte to report. Outbound data bytes appear on `loc_dout` with a one-cycle valid strobe. Inbound data is read from `loc_din`, and a `loc_take` pulse marks each byte consumed. Message Out bytes from the initiator are handed over on `msg_byte`.

All bus signals are active-high at the block's pins. Any inversion for the bus drivers is done outside the block.

Top module: `scsi_tgt_seq`

## Requirements
- R1: The phase lines {MSG, C/D, I/O} take only these codes: 000 Data Out, 001 Data In, 010 Command, 011 Status, 110 Message Out, 111 Message In. The codes 100 and 101 never appear while BSY is driven.
- R2: When SEL and data bit `MY_ID` are high while the initiator's BSY and I/O are low, BSY is asserted two clocks later. With a different ID bit, or with I/O or BSY high, BSY stays low.
- R3: For each byte, REQ stays high until ACK is seen high, then drops. The phase lines do not change while REQ is high.
- R4: REQ is never raised while ACK from the previous byte is still high.
- R5: In Data In, Status and Message In, the byte is driven with odd parity, and the output enable is already on when REQ is seen high.
- R6: The command phase always takes exactly six bytes. If none has a parity error, `cmd_block` holds them (byte k at bits 8k+7..8k) with a one-cycle `cmd_valid`. If any has an error, all six are still taken, `cmd_valid` does not pulse, and Status reports 02h.
- R7: Outbound bytes always carry odd parity. Inbound parity is checked only while `par_chk_en` is high. With checking off, a bad-parity command completes normally.
- R8: A parity error on a Data Out byte ends the data phase after that byte. The block goes straight to Status with 02h, and the bad byte is not passed to `loc_dout`.
- R9: Status is one byte: `loc_status`, or 02h after an error. It is followed by exactly one Message In byte 00h, after which BSY drops.
- R10: A high `bus_rst` clears BSY, REQ, the data enable and the phase lines in the same cycle. The block then returns to idle. The next command is not passed on and reports 02h. The command after that is handled normally.
- R11: If ATN is high when a phase is entered, Message Out comes first. Its byte is given on `msg_byte` with `msg_vld`, and the phase that was due then follows.
- R12: After BSY drops, the phase lines keep their last value for `RELEASE_CLKS` clocks and then go to 000.
- R13: A `loc_len` of zero skips the data phase. Otherwise exactly `loc_len` bytes move in the direction given by `loc_dir` (1 = to the initiator).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Bus reset line |
| bus_sel | input | 1 | Bus SEL line |
| bus_bsy_in | input | 1 | BSY as driven by other devices |
| bus_io_in | input | 1 | I/O as seen on the bus during selection |
| bus_atn | input | 1 | Attention from initiator |
| bus_ack | input | 1 | Acknowledge from initiator |
| bus_db_in | input | 8 | Received data byte |
| bus_dbp_in | input | 1 | Received parity bit |
| bus_bsy_out | output | 1 | BSY driven by this target |
| bus_req | output | 1 | Request |
| bus_msg | output | 1 | MSG phase line |
| bus_cd | output | 1 | C/D phase line |
| bus_io | output | 1 | I/O phase line |
| bus_db_oe | output | 1 | Data bus output enable |
| bus_db_out | output | 8 | Driven data byte |
| bus_dbp_out | output | 1 | Driven odd parity bit |
| par_chk_en | input | 1 | Enable inbound parity checking |
| cmd_valid | output | 1 | One-cycle strobe: command block captured |
| cmd_block | output | 48 | Six captured command bytes |
| loc_go | input | 1 | Executor strobe: start data/status |
| loc_dir | input | 1 | 1 = data to initiator |
| loc_len | input | LEN_W | Data byte count |
| loc_status | input | 8 | Status byte to report |
| loc_din | input | 8 | Next byte to send in Data In |
| loc_take | output | 1 | Strobe: `loc_din` consumed |
| loc_dout | output | 8 | Byte received in Data Out |
| loc_dout_vld | output | 1 | Strobe for `loc_dout` |
| msg_byte | output | 8 | Byte received in Message Out |
| msg_vld | output | 1 | Strobe for `msg_byte` |

## Verification
The hardest case to reach is a bus reset while a data byte is in flight. The unit-attention status then has to come out on the following command and not on the one after it. The bench completes selection and all six command bytes, waits until REQ is up for the first Data In byte, and pulses `bus_rst` there. It checks that the bus is released in that same cycle, then runs two full commands back to back to confirm that the 02h status appears once and is then cleared. A Data Out parity error on an interior byte is reached by corrupting the parity of one chosen byte while the bench acts as initiator. The bench checks that the data phase is cut short right after that byte.

// File: rtl/scsi_tgt_pkg.sv
`timescale 1ns/1ps
package scsi_tgt_pkg;

    localparam int CDB_LEN = 6;
    localparam int CDB_IW  = $clog2(CDB_LEN);

    localparam logic [7:0] STS_CHECK = 8'h02;
    localparam logic [7:0] MSG_DONE  = 8'h00;

    // {MSG, C/D, I/O}
    localparam logic [2:0] PH_DOUT = 3'b000;
    localparam logic [2:0] PH_DIN  = 3'b001;
    localparam logic [2:0] PH_CMD  = 3'b010;
    localparam logic [2:0] PH_STAT = 3'b011;
    localparam logic [2:0] PH_MSGO = 3'b110;
    localparam logic [2:0] PH_MSGI = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_WAITGO, ST_DATA,
        ST_STAT, ST_MSGI, ST_MSGO, ST_DROP
    } tgt_state_e;

    typedef enum logic [1:0] {
        HS_IDLE, HS_SETUP, HS_REQ, HS_REL
    } hs_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
    } hs_rx_t;

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic logic is_xfer(input tgt_state_e s);
        return (s == ST_CMD) || (s == ST_DATA) || (s == ST_STAT) ||
               (s == ST_MSGI) || (s == ST_MSGO);
    endfunction

    function automatic logic [2:0] phase_of(input tgt_state_e s, input logic to_init);
        case (s)
            ST_CMD:  return PH_CMD;
            ST_DATA: return to_init ? PH_DIN : PH_DOUT;
            ST_STAT: return PH_STAT;
            ST_MSGI: return PH_MSGI;
            ST_MSGO: return PH_MSGO;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/scsi_tgt_seldet.sv
`timescale 1ns/1ps
module scsi_tgt_seldet (
    input  logic clk,
    input  logic clr,
    input  logic arm,
    input  logic sel,
    input  logic bsy,
    input  logic io,
    input  logic id_bit,
    output logic hit
);
    // Registered selection qualifier: one clock of settling on the bus lines.
    always_ff @(posedge clk) begin
        if (clr) hit <= 1'b0;
        else     hit <= arm && sel && id_bit && !bsy && !io;
    end
endmodule

// File: rtl/scsi_tgt_hs.sv
`timescale 1ns/1ps
module scsi_tgt_hs
    import scsi_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       start,
    input  logic       to_init,
    input  logic       chk_en,
    input  logic [7:0] tx_byte,
    input  logic       ack,
    input  logic [7:0] db_in,
    input  logic       dbp_in,
    output logic       req,
    output logic       oe,
    output logic [7:0] db_out,
    output logic       dbp_out,
    output logic       idle,
    output logic       done,
    output hs_rx_t     rx
);
    hs_state_e  st;
    logic       dir_q;
    logic [7:0] tx_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            st    <= HS_IDLE;
            dir_q <= 1'b0;
            tx_q  <= '0;
            rx    <= '0;
        end else begin
            case (st)
                HS_IDLE: if (start) begin
                    st    <= HS_SETUP;
                    dir_q <= to_init;
                    tx_q  <= tx_byte;
                end
                // data settles on the bus; REQ waits for ACK of the prior byte to fall
                HS_SETUP: if (!ack) st <= HS_REQ;
                HS_REQ: if (ack) begin
                    st      <= HS_REL;
                    rx.data <= db_in;
                    rx.perr <= !dir_q && chk_en && !(^{db_in, dbp_in});
                end
                HS_REL: if (!ack) st <= HS_IDLE;
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign req     = (st == HS_REQ);
    assign oe      = dir_q && (st != HS_IDLE);
    assign db_out  = tx_q;
    assign dbp_out = odd_par(tx_q);
    assign idle    = (st == HS_IDLE);
    assign done    = (st == HS_REL) && !ack;
endmodule

// File: rtl/scsi_tgt_seq.sv
`timescale 1ns/1ps
module scsi_tgt_seq
    import scsi_tgt_pkg::*;
#(
    parameter int MY_ID        = 3,
    parameter int LEN_W        = 8,
    parameter int RELEASE_CLKS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_rst,
    input  logic                   bus_sel,
    input  logic                   bus_bsy_in,
    input  logic                   bus_io_in,
    input  logic                   bus_atn,
    input  logic                   bus_ack,
    input  logic [7:0]             bus_db_in,
    input  logic                   bus_dbp_in,
    output logic                   bus_bsy_out,
    output logic                   bus_req,
    output logic                   bus_msg,
    output logic                   bus_cd,
    output logic                   bus_io,
    output logic                   bus_db_oe,
    output logic [7:0]             bus_db_out,
    output logic                   bus_dbp_out,
    input  logic                   par_chk_en,
    output logic                   cmd_valid,
    output logic [8*CDB_LEN-1:0]   cmd_block,
    input  logic                   loc_go,
    input  logic                   loc_dir,
    input  logic [LEN_W-1:0]       loc_len,
    input  logic [7:0]             loc_status,
    input  logic [7:0]             loc_din,
    output logic                   loc_take,
    output logic [7:0]             loc_dout,
    output logic                   loc_dout_vld,
    output logic [7:0]             msg_byte,
    output logic                   msg_vld
);
    localparam int RCW = $clog2(RELEASE_CLKS + 1);
    localparam int CW  = (RCW > LEN_W) ? RCW : LEN_W;

    tgt_state_e       st, st_n, ret, ret_n, go_x;
    logic             go;
    logic [CW-1:0]    cnt;
    logic             pend, err, uatt, dir, dir_n;
    logic [LEN_W-1:0] len;
    logic [7:0]       sts_q, tx_byte, sts_byte;
    logic [2:0]       pb;
    logic [7:0]       cmd_r [CDB_LEN];
    logic             clr, sel_hit;
    logic             hs_start, hs_idle, hs_done, hs_req, hs_oe, hs_dbp;
    logic [7:0]       hs_dout;
    hs_rx_t           hs_rx;
    logic             cmd_last, data_last, cmd_bad;

    assign clr = rst || bus_rst;

    scsi_tgt_seldet u_sel (
        .clk(clk), .clr(clr), .arm(st == ST_IDLE), .sel(bus_sel),
        .bsy(bus_bsy_in), .io(bus_io_in), .id_bit(bus_db_in[MY_ID]), .hit(sel_hit)
    );

    assign hs_start = is_xfer(st) && hs_idle && !pend;

    scsi_tgt_hs u_hs (
        .clk(clk), .clr(clr), .start(hs_start), .to_init(pb[0]), .chk_en(par_chk_en),
        .tx_byte(tx_byte), .ack(bus_ack), .db_in(bus_db_in), .dbp_in(bus_dbp_in),
        .req(hs_req), .oe(hs_oe), .db_out(hs_dout), .dbp_out(hs_dbp),
        .idle(hs_idle), .done(hs_done), .rx(hs_rx)
    );

    assign sts_byte = (err || uatt) ? STS_CHECK : sts_q;

    always_comb begin
        case (st)
            ST_DATA: tx_byte = loc_din;
            ST_STAT: tx_byte = sts_byte;
            default: tx_byte = MSG_DONE;
        endcase
    end

    assign cmd_last  = hs_done && (cnt == CW'(CDB_LEN - 1));
    assign data_last = hs_done && (hs_rx.perr || (cnt == CW'(len) - CW'(1)));
    assign cmd_bad   = err || uatt || hs_rx.perr;
    assign dir_n     = (st == ST_WAITGO && loc_go) ? loc_dir : dir;

    // next state; every phase entry passes through the ATN check
    always_comb begin
        go   = 1'b0;
        go_x = ST_IDLE;
        st_n = st;
        case (st)
            ST_IDLE:   if (sel_hit) begin go = 1'b1; go_x = ST_CMD; end
            ST_CMD:    if (cmd_last) begin
                           if (cmd_bad) begin go = 1'b1; go_x = ST_STAT; end
                           else st_n = ST_WAITGO;
                       end
            ST_WAITGO: if (loc_go) begin
                           go   = 1'b1;
                           go_x = (loc_len == '0) ? ST_STAT : ST_DATA;
                       end
            ST_DATA:   if (data_last) begin go = 1'b1; go_x = ST_STAT; end
            ST_STAT:   if (hs_done) begin go = 1'b1; go_x = ST_MSGI; end
            ST_MSGI:   if (hs_done) st_n = ST_DROP;
            ST_MSGO:   if (hs_done) begin go = 1'b1; go_x = ret; end
            ST_DROP:   if (cnt == CW'(RELEASE_CLKS - 1)) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
        ret_n = go ? go_x : ret;
        if (go) st_n = bus_atn ? ST_MSGO : go_x;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st           <= ST_IDLE;
            ret          <= ST_IDLE;
            cnt          <= '0;
            pend         <= 1'b0;
            err          <= 1'b0;
            uatt         <= bus_rst && !rst;
            dir          <= 1'b0;
            len          <= '0;
            sts_q        <= '0;
            pb           <= 3'b000;
            cmd_valid    <= 1'b0;
            loc_take     <= 1'b0;
            loc_dout     <= '0;
            loc_dout_vld <= 1'b0;
            msg_byte     <= '0;
            msg_vld      <= 1'b0;
        end else begin
            st   <= st_n;
            ret  <= ret_n;
            dir  <= dir_n;
            if (st_n != st)                  cnt <= '0;
            else if (st == ST_DROP || hs_done) cnt <= cnt + CW'(1);
            if (hs_start)     pend <= 1'b1;
            else if (hs_done) pend <= 1'b0;

            if (st == ST_IDLE && sel_hit) err <= 1'b0;
            else if (hs_done && hs_rx.perr && (st == ST_CMD || st == ST_DATA)) err <= 1'b1;
            if (st == ST_STAT && hs_done) uatt <= 1'b0;

            if (st == ST_WAITGO && loc_go) begin
                len   <= loc_len;
                sts_q <= loc_status;
            end

            if (st_n == ST_IDLE)   pb <= 3'b000;
            else if (is_xfer(st_n)) pb <= phase_of(st_n, dir_n);

            cmd_valid    <= (st == ST_CMD) && (st_n == ST_WAITGO);
            loc_take     <= hs_start && (st == ST_DATA) && dir;
            loc_dout_vld <= hs_done && (st == ST_DATA) && !dir && !hs_rx.perr;
            if (hs_done && st == ST_DATA) loc_dout <= hs_rx.data;
            msg_vld      <= hs_done && (st == ST_MSGO);
            if (hs_done && st == ST_MSGO) msg_byte <= hs_rx.data;
        end
    end

    always_ff @(posedge clk) begin
        if (st == ST_CMD && hs_done) cmd_r[cnt[CDB_IW-1:0]] <= hs_rx.data;
    end

    for (genvar k = 0; k < CDB_LEN; k++) begin : g_cdb
        assign cmd_block[8*k +: 8] = cmd_r[k];
    end

    // bus reset releases every driven line in the same cycle
    assign bus_bsy_out = !bus_rst && (st != ST_IDLE) && (st != ST_DROP);
    assign bus_req     = !bus_rst && hs_req;
    assign bus_db_oe   = !bus_rst && hs_oe;
    assign bus_db_out  = hs_dout;
    assign bus_dbp_out = hs_dbp;
    assign bus_msg     = !bus_rst && pb[2];
    assign bus_cd      = !bus_rst && pb[1];
    assign bus_io      = !bus_rst && pb[0];
endmodule

// File: rtl/scsi_tgt_seq_chk.sv
`timescale 1ns/1ps
module scsi_tgt_seq_chk (
    input logic clk,
    input logic rst,
    input logic bus_rst,
    input logic bus_sel,
    input logic bus_ack,
    input logic bus_bsy_out,
    input logic bus_req,
    input logic bus_msg,
    input logic bus_cd,
    input logic bus_io,
    input logic bus_db_oe
);
    p_phase_code_r1: assert property (@(posedge clk) disable iff (rst)
        bus_bsy_out |-> !(bus_msg && !bus_cd));

    p_sel_to_bsy_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_bsy_out) |-> $past(bus_sel, 2));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !bus_rst) |=> (bus_req || bus_rst));

    p_phase_stable_r3: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (bus_req && $past(bus_req)) |-> $stable({bus_msg, bus_cd, bus_io}));

    p_req_after_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !$past(bus_ack));

    p_data_before_req_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_req) && bus_io) |-> $past(bus_db_oe));

    p_rst_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rst) |-> (!bus_bsy_out && !bus_req));

    p_lines_held_r12: assert property (@(posedge clk) disable iff (rst || bus_rst)
        $fell(bus_bsy_out) |-> (bus_msg && bus_cd && bus_io));
endmodule

bind scsi_tgt_seq scsi_tgt_seq_chk u_chk (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_sel(bus_sel), .bus_ack(bus_ack),
    .bus_bsy_out(bus_bsy_out), .bus_req(bus_req), .bus_msg(bus_msg), .bus_cd(bus_cd),
    .bus_io(bus_io), .bus_db_oe(bus_db_oe)
);

// File: tb/scsi_tgt_seq_test.sv
`timescale 1ns/1ps
module scsi_tgt_seq_test;
    localparam int ID  = 3;
    localparam int REL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rst = 0, bus_sel = 0, bus_bsy_in = 0, bus_io_in = 0, bus_atn = 0, bus_ack = 0;
    logic [7:0] bus_db_in = 0;
    logic bus_dbp_in = 0;
    logic bus_bsy_out, bus_req, bus_msg, bus_cd, bus_io, bus_db_oe, bus_dbp_out;
    logic [7:0] bus_db_out;
    logic par_chk_en = 1;
    logic cmd_valid;
    logic [47:0] cmd_block;
    logic loc_go = 0, loc_dir = 0;
    logic [7:0] loc_len = 0, loc_status = 0, loc_din;
    logic loc_take, loc_dout_vld, msg_vld;
    logic [7:0] loc_dout, msg_byte;

    always #4 clk = ~clk;

    scsi_tgt_seq #(.MY_ID(ID), .LEN_W(8), .RELEASE_CLKS(REL)) uut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_sel(bus_sel), .bus_bsy_in(bus_bsy_in),
        .bus_io_in(bus_io_in), .bus_atn(bus_atn), .bus_ack(bus_ack), .bus_db_in(bus_db_in),
        .bus_dbp_in(bus_dbp_in), .bus_bsy_out(bus_bsy_out), .bus_req(bus_req),
        .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io), .bus_db_oe(bus_db_oe),
        .bus_db_out(bus_db_out), .bus_dbp_out(bus_dbp_out), .par_chk_en(par_chk_en),
        .cmd_valid(cmd_valid), .cmd_block(cmd_block), .loc_go(loc_go), .loc_dir(loc_dir),
        .loc_len(loc_len), .loc_status(loc_status), .loc_din(loc_din), .loc_take(loc_take),
        .loc_dout(loc_dout), .loc_dout_vld(loc_dout_vld), .msg_byte(msg_byte), .msg_vld(msg_vld)
    );

    int tests = 0, fails = 0;
    int txn_id = 0;
    int cur_seed = 0, cfg_len = 0, bad_cmd = -1, bad_data = -1;
    logic cfg_dir = 0;
    logic [7:0] cfg_status = 0;

    function automatic logic [7:0] pat_in(int s, int k);
        return 8'((s * 7 + k * 37 + 1) & 255);
    endfunction
    function automatic logic [7:0] pat_out(int s, int k);
        return 8'((s * 11 + k * 53 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // local executor model
    int din_idx = 0, seen_txn = 0, n_dout = 0;
    logic [7:0] dout_log [64];
    bit cmd_seen = 0, msg_seen = 0;
    logic [47:0] cmd_seen_blk = 0;
    logic [7:0] msg_val = 0;
    assign loc_din = pat_in(cur_seed, din_idx);

    always @(negedge clk) begin
        if (seen_txn != txn_id) begin
            seen_txn = txn_id; din_idx = 0; n_dout = 0;
            cmd_seen = 0; msg_seen = 0;
        end
        loc_go = 0;
        if (cmd_valid) begin
            cmd_seen = 1; cmd_seen_blk = cmd_block;
            loc_go = 1; loc_dir = cfg_dir; loc_len = 8'(cfg_len); loc_status = cfg_status;
        end
        if (loc_take) din_idx++;
        if (loc_dout_vld && n_dout < 64) begin dout_log[n_dout] = loc_dout; n_dout++; end
        if (msg_vld) begin msg_seen = 1; msg_val = msg_byte; end
    end

    // initiator model
    logic [2:0] ph_log [64];
    logic [7:0] by_log [64];
    int n_log = 0, k_cmd = 0, k_dout = 0, par_bad = 0;

    task automatic select_me();
        @(negedge clk);
        bus_db_in = 8'(1 << ID); bus_sel = 1;
        @(negedge clk);
        chk(bus_bsy_out == 0, "R2 bsy one clock after sel", bus_bsy_out, 0);
        @(negedge clk);
        chk(bus_bsy_out == 1, "R2 bsy two clocks after sel", bus_bsy_out, 1);
        bus_sel = 0; bus_db_in = 0;
    endtask

    task automatic one_byte(output bit ended);
        logic [2:0] ph;
        logic [7:0] b;
        bit bad;
        ended = 0; bad = 0;
        while (!(bus_req || !bus_bsy_out)) @(negedge clk);
        if (!bus_bsy_out) begin ended = 1; return; end
        ph = {bus_msg, bus_cd, bus_io};
        if (bus_io) begin
            if (!bus_db_oe) par_bad++;
            b = bus_db_out;
            if (!(^{bus_db_out, bus_dbp_out})) par_bad++;
        end else begin
            case (ph)
                3'b010: begin b = 8'(cur_seed + k_cmd * 3); bad = (k_cmd == bad_cmd); k_cmd++; end
                3'b000: begin b = pat_out(cur_seed, k_dout); bad = (k_dout == bad_data); k_dout++; end
                default: begin b = 8'h06; bus_atn = 0; end
            endcase
            bus_db_in = b; bus_dbp_in = (~^b) ^ bad;
        end
        if (n_log < 64) begin ph_log[n_log] = ph; by_log[n_log] = b; n_log++; end
        bus_ack = 1;
        while (bus_req) @(negedge clk);
        bus_ack = 0; bus_db_in = 0; bus_dbp_in = 0;
    endtask

    task automatic run_txn(input int seed, input logic dir, input int len, input logic [7:0] sts,
                           input int bcmd, input int bdat, input bit atn_pre, input bit uatt_exp);
        logic [2:0] eph [64];
        logic [7:0] eby [64];
        int ne, ndata, mism, nrel, nd_exp;
        bit cmd_bad, derr, ended;
        txn_id++; cur_seed = seed; cfg_dir = dir; cfg_len = len; cfg_status = sts;
        bad_cmd = bcmd; bad_data = bdat;
        n_log = 0; k_cmd = 0; k_dout = 0; par_bad = 0;
        bus_atn = atn_pre;
        select_me();
        ended = 0;
        while (!ended) one_byte(ended);
        nrel = 0;
        while ({bus_msg, bus_cd, bus_io} != 3'b000) begin @(negedge clk); nrel++; end
        chk(nrel == REL, "R12 phase lines held after BSY drop", nrel, REL);
        // expected bus trace
        ne = 0;
        if (atn_pre) begin eph[ne] = 3'b110; eby[ne] = 8'h06; ne++; end
        for (int k = 0; k < 6; k++) begin eph[ne] = 3'b010; eby[ne] = 8'(seed + k * 3); ne++; end
        cmd_bad = uatt_exp || (bcmd >= 0 && par_chk_en);
        derr = 0; ndata = 0;
        if (!cmd_bad) begin
            ndata = len;
            if (!dir && bdat >= 0 && bdat < len && par_chk_en) begin ndata = bdat + 1; derr = 1; end
            for (int k = 0; k < ndata; k++) begin
                eph[ne] = {2'b00, dir};
                eby[ne] = dir ? pat_in(seed, k) : pat_out(seed, k);
                ne++;
            end
        end
        eph[ne] = 3'b011; eby[ne] = (cmd_bad || derr) ? 8'h02 : sts; ne++;
        eph[ne] = 3'b111; eby[ne] = 8'h00; ne++;
        mism = 0;
        for (int k = 0; k < ne && k < n_log; k++)
            if (eph[k] != ph_log[k] || eby[k] != by_log[k]) mism++;
        chk(n_log == ne, "R1/R13 phase count", n_log, ne);
        chk(mism == 0, "R1 phase codes and bytes", mism, 0);
        chk(n_log >= 2 && by_log[n_log-2] == eby[ne-2], "R9 status byte",
            n_log >= 2 ? by_log[n_log-2] : -1, eby[ne-2]);
        chk(n_log >= 1 && ph_log[n_log-1] == 3'b111 && by_log[n_log-1] == 0,
            "R9 message in 00h", n_log >= 1 ? by_log[n_log-1] : -1, 0);
        chk(par_bad == 0, "R5/R7 odd parity and enable on inbound", par_bad, 0);
        chk(cmd_seen == !cmd_bad, "R6 cmd_valid", cmd_seen, !cmd_bad);
        if (!cmd_bad) begin
            mism = 0;
            for (int k = 0; k < 6; k++) if (cmd_seen_blk[8*k +: 8] != 8'(seed + k * 3)) mism++;
            chk(mism == 0, "R6 command block bytes", mism, 0);
        end
        nd_exp = (!cmd_bad && !dir) ? (derr ? ndata - 1 : ndata) : 0;
        chk(n_dout == nd_exp, "R8/R13 local data out count", n_dout, nd_exp);
        mism = 0;
        for (int k = 0; k < n_dout && k < 64; k++) if (dout_log[k] != pat_out(seed, k)) mism++;
        chk(mism == 0, "R13 local data out bytes", mism, 0);
        if (atn_pre) chk(msg_seen && msg_val == 8'h06, "R11 message out byte", msg_val, 8'h06);
        repeat (2) @(negedge clk);
    endtask

    task automatic no_select(input logic [7:0] db, input logic io, input logic bsy, input string what);
        int hits;
        hits = 0;
        @(negedge clk);
        bus_db_in = db; bus_io_in = io; bus_bsy_in = bsy; bus_sel = 1;
        repeat (5) begin @(negedge clk); if (bus_bsy_out) hits++; end
        bus_sel = 0; bus_db_in = 0; bus_io_in = 0; bus_bsy_in = 0;
        repeat (2) @(negedge clk);
        chk(hits == 0, what, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit ended;
        int seed;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!bus_bsy_out && !bus_req && !bus_db_oe, "R1 reset idle", bus_bsy_out, 0);
        chk({bus_msg, bus_cd, bus_io} == 0, "R12 reset phase lines", {bus_msg, bus_cd, bus_io}, 0);

        no_select(8'(1 << (ID ^ 1)), 0, 0, "R2 other ID ignored");
        no_select(8'(1 << ID), 1, 0, "R2 I/O high ignored");
        no_select(8'(1 << ID), 0, 1, "R2 BSY high ignored");

        seed = 1;
        for (int d = 0; d < 2; d++) begin
            for (int li = 0; li < 4; li++) begin
                int lens [4] = '{0, 1, 3, 7};
                run_txn(seed, d[0], lens[li], 8'(seed * 2 + 8), -1, -1, 0, 0); // R13 sweep
                seed++;
            end
        end

        run_txn(40, 1, 2, 8'h00, 2, -1, 0, 0);   // R6 command parity error
        run_txn(41, 1, 2, 8'h00, 5, -1, 0, 0);   // R6 error on last command byte
        par_chk_en = 0;
        run_txn(42, 0, 3, 8'h00, 2, 1, 0, 0);    // R7 checking off
        par_chk_en = 1;
        run_txn(43, 0, 4, 8'h00, -1, 1, 0, 0);   // R8 data out parity error
        run_txn(44, 0, 4, 8'h00, -1, 0, 0, 0);   // R8 first data byte bad
        run_txn(45, 1, 2, 8'h10, -1, -1, 1, 0);  // R11 ATN before selection
        run_txn(46, 0, 0, 8'h18, -1, -1, 1, 0);  // R11 with zero length

        // R10: bus reset while a Data In byte is requested
        txn_id++; cur_seed = 50; cfg_dir = 1; cfg_len = 4; cfg_status = 0;
        bad_cmd = -1; bad_data = -1; n_log = 0; k_cmd = 0; k_dout = 0; par_bad = 0;
        select_me();
        repeat (6) one_byte(ended);
        while (!bus_req) @(negedge clk);
        bus_rst = 1;
        #1;
        chk(!bus_bsy_out && !bus_req && !bus_db_oe && {bus_msg, bus_cd, bus_io} == 0,
            "R10 lines released at once", {bus_bsy_out, bus_req, bus_db_oe, bus_msg, bus_cd, bus_io}, 0);
        @(negedge clk);
        bus_rst = 0;
        @(negedge clk);
        chk(!bus_bsy_out && {bus_msg, bus_cd, bus_io} == 0, "R10 back to idle",
            {bus_bsy_out, bus_msg, bus_cd, bus_io}, 0);
        run_txn(51, 1, 2, 8'h00, -1, -1, 0, 1);  // R10 unit attention reported
        run_txn(52, 1, 2, 8'h00, -1, -1, 0, 0);  // R10 cleared afterwards

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule